// File: doc/BRIEF.md
# SOF-Referenced Oscillator Trim Calibrator

This block keeps a local timer oscillator near its nominal frequency by using USB start-of-frame (SOF) events as a 1 ms time reference. It counts local clock cycles from one SOF pulse to the next. It then sorts that count into one of nine buckets, which are bounded by eight programmable ascending thresholds. Each bucket has a programmable operation that moves a 5-bit fine trim code. The operation can be a binary-search step, a single add, a single subtract, or nothing. The nominal count is the clock frequency divided by 1000, which is 24000 at 24 MHz. At reset the thresholds sit at fixed percentages of that count. The two buckets next to the target form a deadband, and counts below the lowest threshold are treated as glitches.

When the fine code is pinned at an end of its range and the engine still asks to move it further, the block sets a sticky status bit and can raise an interrupt. Software then moves the coarse trim, which the block only stores and passes on. A small register interface sets the thresholds, the bucket operations, the enables, the starting trim values and the interrupt controls.

The control state machine has four states:
- IDLE: calibration is off. The step size is held at 16.
- ARM: waits for the first SOF, which only starts the count.
- MEASURE: counts and classifies each period.
- HALT: frozen after a no-op bucket while stop-on-no-op is set.

Transitions:
- IDLE→ARM when the enable is set.
- ARM→MEASURE on an SOF.
- MEASURE→HALT on a classified no-op with stop-on-no-op set.
- Any state→IDLE when the enable is cleared.

Top module: `sof_trim_cal`

## Requirements
- R1: After reset, the threshold registers 0x00-0x07 read 16800, 19200, 21600, 23970, 24000, 24030, 26400 and 28800. The operation registers 0x08-0x10 read 0x00, 0x11, 0x11, 0x03, 0x00, 0x00, 0x02, 0x01 and 0x01. fine_trim is 16 and both interrupt outputs are low.
- R2: The count of a period is the number of clock edges from one SOF edge to the next. The bucket index is the number of thresholds that are less than or equal to the count.
- R3: An operation code has its type in bits [1:0]: 0 no-op, 1 binary step, 2 add, 3 subtract. For a binary step, bit 4 set means down. A binary step moves the fine code by the current step (clamped to the range 0..31) and then halves the step, never below 1. The step is 16 after reset, while disabled, and after a sync.
- R4: An add or subtract moves the fine code by exactly 1. A no-op leaves it unchanged.
- R5: A decrease requested while the fine code is 0 sets status bit 2 (register 0x15) and leaves the code at 0. A binary down step that clamps from a nonzero code to 0 sets no flag.
- R6: An increase requested while the fine code is 31 sets status bit 3 and leaves the code at 31.
- R7: irq_underrun is status bit 2 AND enable bit 2 of register 0x14. irq_overflow is the same for bit 3. Writing 1 to a status bit clears it.
- R8: The first SOF after the enable is set only starts the count and changes nothing.
- R9: The cycle count saturates at 0xFFFF, so a missing SOF falls into the top bucket.
- R10: Control bit 2 (stop-on-no-op), when set, freezes calibration at the first classified no-op until the enable is cleared and set again. When it is clear, calibration continues.
- R11: Control bit 3 set selects the engine's fine code for fine_trim. When clear, fine_trim shows the initial fine register 0x12.
- R12: Any write to 0x16 (sync) copies register 0x12 into the engine's fine code and register 0x13 into coarse_trim.
- R13: While control bit 0 (enable) is clear, SOF pulses do not change the engine's fine code.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Timer clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 5 | Register address |
| cfg_wdata | input | 16 | Register write data |
| cfg_rdata | output | 16 | Register read data for cfg_addr |
| sof_in | input | 1 | One-cycle SOF pulse, synchronous to clk |
| fine_trim | output | 5 | Fine trim code sent to the oscillator |
| coarse_trim | output | 8 | Coarse trim code sent to the oscillator |
| irq_underrun | output | 1 | Fine trim underrun interrupt |
| irq_overflow | output | 1 | Fine trim overflow interrupt |

## Verification
Two corners are hardest to reach from the ports. The first is counter saturation: the bench raises the top threshold to 0xFFFF and makes the bucket below it a no-op. It then waits more than 65535 cycles between SOF pulses. Only a saturated count can reach the binary-up bucket, while a wrapped count would land in the no-op bucket. The second is saturating the trim: the bench loads edge values through sync, then asks for one more step in the pinned direction. A model in the bench replays the measured periods through the bucket map and predicts each trim code.

// File: rtl/sof_cal_pkg.sv
package sof_cal_pkg;

    localparam int NUM_THR = 8;
    localparam int NUM_BKT = NUM_THR + 1;
    localparam int BKT_W   = $clog2(NUM_BKT);
    localparam int OPQ_W   = 3;   // stored form: {down, type[1:0]}

    // register addresses
    localparam int A_THR0        = 0;
    localparam int A_OP0         = A_THR0 + NUM_THR;
    localparam int A_CTRL        = A_OP0 + NUM_BKT;
    localparam int A_INIT_FINE   = A_CTRL + 1;
    localparam int A_INIT_COARSE = A_CTRL + 2;
    localparam int A_INT_EN      = A_CTRL + 3;
    localparam int A_INT_ST      = A_CTRL + 4;
    localparam int A_SYNC        = A_CTRL + 5;
    localparam int A_ACT_FINE    = A_CTRL + 6;

    // bit positions
    localparam int CTRL_EN_BIT   = 0;
    localparam int CTRL_STOP_BIT = 2;
    localparam int CTRL_SRC_BIT  = 3;
    localparam int INT_UNF_BIT   = 2;
    localparam int INT_OVF_BIT   = 3;
    localparam int OP_DOWN_BIT   = 4;

    typedef enum logic [1:0] {
        OP_NOP = 2'd0,
        OP_BIN = 2'd1,
        OP_ADD = 2'd2,
        OP_SUB = 2'd3
    } op_t;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_ARM  = 2'd1,
        ST_MEAS = 2'd2,
        ST_HALT = 2'd3
    } cal_state_t;

    // reset threshold i as a fraction of the nominal count
    function automatic longint default_thr(input int idx, input longint target);
        case (idx)
            0:       return target * 70 / 100;
            1:       return target * 80 / 100;
            2:       return target * 90 / 100;
            3:       return target * 998750 / 1000000;
            4:       return target;
            5:       return target * 1001250 / 1000000;
            6:       return target * 110 / 100;
            default: return target * 120 / 100;
        endcase
    endfunction

    // reset operation of bucket i, stored as {down, type}
    function automatic logic [OPQ_W-1:0] default_op(input int idx);
        case (idx)
            1, 2:    return {1'b1, OP_BIN};
            3:       return {1'b0, OP_SUB};
            6:       return {1'b0, OP_ADD};
            7, 8:    return {1'b0, OP_BIN};
            default: return {1'b0, OP_NOP};
        endcase
    endfunction

endpackage

// File: rtl/sof_cal_regs.sv
module sof_cal_regs
    import sof_cal_pkg::*;
#(
    parameter int ADDR_W   = 5,
    parameter int DATA_W   = 16,
    parameter int CNT_W    = 16,
    parameter int TRIM_W   = 5,
    parameter int COARSE_W = 8,
    parameter int TARGET   = 24000
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             cfg_we,
    input  logic [ADDR_W-1:0]                cfg_addr,
    input  logic [DATA_W-1:0]                cfg_wdata,
    output logic [DATA_W-1:0]                cfg_rdata,
    input  logic [TRIM_W-1:0]                eng_fine,
    input  logic                             unf_evt,
    input  logic                             ovf_evt,
    output logic [NUM_THR-1:0][CNT_W-1:0]    thr,
    output logic [NUM_BKT-1:0][OPQ_W-1:0]    ops,
    output logic                             ctrl_en,
    output logic                             ctrl_stop,
    output logic                             ctrl_src,
    output logic [TRIM_W-1:0]                init_fine,
    output logic [COARSE_W-1:0]              act_coarse,
    output logic                             sync_pulse,
    output logic                             st_unf,
    output logic                             st_ovf,
    output logic                             irq_unf,
    output logic                             irq_ovf
);

    localparam logic [TRIM_W-1:0] FINE_RST = TRIM_W'(1 << (TRIM_W - 1));

    logic [COARSE_W-1:0] init_coarse;
    logic                en_unf, en_ovf;
    logic                wr_ctrl, wr_ifine, wr_icoarse, wr_ien, wr_ist;

    assign wr_ctrl    = cfg_we && (cfg_addr == ADDR_W'(A_CTRL));
    assign wr_ifine   = cfg_we && (cfg_addr == ADDR_W'(A_INIT_FINE));
    assign wr_icoarse = cfg_we && (cfg_addr == ADDR_W'(A_INIT_COARSE));
    assign wr_ien     = cfg_we && (cfg_addr == ADDR_W'(A_INT_EN));
    assign wr_ist     = cfg_we && (cfg_addr == ADDR_W'(A_INT_ST));
    assign sync_pulse = cfg_we && (cfg_addr == ADDR_W'(A_SYNC));

    // threshold and bucket-operation tables
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_THR; i++)
                thr[i] <= CNT_W'(default_thr(i, longint'(TARGET)));
            for (int i = 0; i < NUM_BKT; i++)
                ops[i] <= default_op(i);
        end else if (cfg_we) begin
            for (int i = 0; i < NUM_THR; i++)
                if (cfg_addr == ADDR_W'(A_THR0 + i))
                    thr[i] <= cfg_wdata[CNT_W-1:0];
            for (int i = 0; i < NUM_BKT; i++)
                if (cfg_addr == ADDR_W'(A_OP0 + i))
                    ops[i] <= {cfg_wdata[OP_DOWN_BIT], cfg_wdata[1:0]};
        end
    end

    // control, initial trims and interrupt enables
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_en     <= 1'b0;
            ctrl_stop   <= 1'b0;
            ctrl_src    <= 1'b0;
            init_fine   <= FINE_RST;
            init_coarse <= '0;
            act_coarse  <= '0;
            en_unf      <= 1'b0;
            en_ovf      <= 1'b0;
        end else begin
            if (wr_ctrl) begin
                ctrl_en   <= cfg_wdata[CTRL_EN_BIT];
                ctrl_stop <= cfg_wdata[CTRL_STOP_BIT];
                ctrl_src  <= cfg_wdata[CTRL_SRC_BIT];
            end
            if (wr_ifine)   init_fine   <= cfg_wdata[TRIM_W-1:0];
            if (wr_icoarse) init_coarse <= cfg_wdata[COARSE_W-1:0];
            if (sync_pulse) act_coarse  <= init_coarse;
            if (wr_ien) begin
                en_unf <= cfg_wdata[INT_UNF_BIT];
                en_ovf <= cfg_wdata[INT_OVF_BIT];
            end
        end
    end

    // sticky status, set has priority over write-one-to-clear
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_unf <= 1'b0;
            st_ovf <= 1'b0;
        end else begin
            if (unf_evt)
                st_unf <= 1'b1;
            else if (wr_ist && cfg_wdata[INT_UNF_BIT])
                st_unf <= 1'b0;
            if (ovf_evt)
                st_ovf <= 1'b1;
            else if (wr_ist && cfg_wdata[INT_OVF_BIT])
                st_ovf <= 1'b0;
        end
    end

    assign irq_unf = st_unf & en_unf;
    assign irq_ovf = st_ovf & en_ovf;

    // read mux
    always_comb begin
        cfg_rdata = '0;
        for (int i = 0; i < NUM_THR; i++)
            if (cfg_addr == ADDR_W'(A_THR0 + i))
                cfg_rdata = DATA_W'(thr[i]);
        for (int i = 0; i < NUM_BKT; i++)
            if (cfg_addr == ADDR_W'(A_OP0 + i)) begin
                cfg_rdata[OP_DOWN_BIT] = ops[i][2];
                cfg_rdata[1:0]         = ops[i][1:0];
            end
        if (cfg_addr == ADDR_W'(A_CTRL)) begin
            cfg_rdata[CTRL_EN_BIT]   = ctrl_en;
            cfg_rdata[CTRL_STOP_BIT] = ctrl_stop;
            cfg_rdata[CTRL_SRC_BIT]  = ctrl_src;
        end
        if (cfg_addr == ADDR_W'(A_INIT_FINE))   cfg_rdata = DATA_W'(init_fine);
        if (cfg_addr == ADDR_W'(A_INIT_COARSE)) cfg_rdata = DATA_W'(init_coarse);
        if (cfg_addr == ADDR_W'(A_INT_EN)) begin
            cfg_rdata[INT_UNF_BIT] = en_unf;
            cfg_rdata[INT_OVF_BIT] = en_ovf;
        end
        if (cfg_addr == ADDR_W'(A_INT_ST)) begin
            cfg_rdata[INT_UNF_BIT] = st_unf;
            cfg_rdata[INT_OVF_BIT] = st_ovf;
        end
        if (cfg_addr == ADDR_W'(A_ACT_FINE))    cfg_rdata = DATA_W'(eng_fine);
    end

endmodule

// File: rtl/sof_cal_classify.sv
module sof_cal_classify
    import sof_cal_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic [CNT_W-1:0]              cnt,
    input  logic [NUM_THR-1:0][CNT_W-1:0] thr,
    output logic [BKT_W-1:0]              bucket
);

    logic [NUM_THR-1:0] at_or_above;

    // one comparator per threshold
    for (genvar g = 0; g < NUM_THR; g++) begin : g_cmp
        assign at_or_above[g] = (cnt >= thr[g]);
    end

    // ascending thresholds: bucket = thresholds passed
    always_comb begin
        bucket = '0;
        for (int i = 0; i < NUM_THR; i++)
            bucket = bucket + BKT_W'(at_or_above[i]);
    end

endmodule

// File: rtl/sof_cal_trim.sv
module sof_cal_trim
    import sof_cal_pkg::*;
#(
    parameter int TRIM_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hold_step,
    input  logic              apply,
    input  op_t               op_type,
    input  logic              op_down,
    input  logic              sync,
    input  logic [TRIM_W-1:0] init_fine,
    output logic [TRIM_W-1:0] fine,
    output logic [TRIM_W-1:0] step,
    output logic              unf_evt,
    output logic              ovf_evt
);

    localparam logic [TRIM_W-1:0] STEP_INIT = TRIM_W'(1 << (TRIM_W - 1));
    localparam logic [TRIM_W-1:0] FINE_MAX  = '1;
    localparam logic [TRIM_W-1:0] ONE       = TRIM_W'(1);

    logic              want_up, want_dn, is_bin, live;
    logic [TRIM_W-1:0] amount;
    logic [TRIM_W:0]   up_sum;
    logic [TRIM_W-1:0] fine_nxt;

    assign live = apply && !sync;

    always_comb begin
        want_up = 1'b0;
        want_dn = 1'b0;
        is_bin  = 1'b0;
        amount  = ONE;
        unique case (op_type)
            OP_NOP: ;
            OP_BIN: begin
                is_bin  = 1'b1;
                amount  = step;
                want_up = !op_down;
                want_dn = op_down;
            end
            OP_ADD: want_up = 1'b1;
            OP_SUB: want_dn = 1'b1;
        endcase
    end

    assign up_sum = {1'b0, fine} + {1'b0, amount};

    always_comb begin
        fine_nxt = fine;
        if (want_up)
            fine_nxt = (up_sum > {1'b0, FINE_MAX}) ? FINE_MAX : up_sum[TRIM_W-1:0];
        else if (want_dn)
            fine_nxt = (amount > fine) ? '0 : fine - amount;
    end

    assign unf_evt = live && want_dn && (fine == '0);
    assign ovf_evt = live && want_up && (fine == FINE_MAX);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fine <= '0;
            step <= STEP_INIT;
        end else if (sync) begin
            fine <= init_fine;
            step <= STEP_INIT;
        end else if (hold_step) begin
            step <= STEP_INIT;
        end else if (apply) begin
            fine <= fine_nxt;
            if (is_bin)
                step <= (step > ONE) ? (step >> 1) : ONE;
        end
    end

endmodule

// File: rtl/sof_trim_cal.sv
module sof_trim_cal
    import sof_cal_pkg::*;
#(
    parameter int ADDR_W   = 5,
    parameter int DATA_W   = 16,
    parameter int CNT_W    = 16,
    parameter int TRIM_W   = 5,
    parameter int COARSE_W = 8,
    parameter int TARGET   = 24000
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cfg_we,
    input  logic [ADDR_W-1:0]   cfg_addr,
    input  logic [DATA_W-1:0]   cfg_wdata,
    output logic [DATA_W-1:0]   cfg_rdata,
    input  logic                sof_in,
    output logic [TRIM_W-1:0]   fine_trim,
    output logic [COARSE_W-1:0] coarse_trim,
    output logic                irq_underrun,
    output logic                irq_overflow
);

    localparam logic [CNT_W-1:0] CNT_MAX = '1;
    localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

    cal_state_t state, state_nxt;

    logic [NUM_THR-1:0][CNT_W-1:0] thr;
    logic [NUM_BKT-1:0][OPQ_W-1:0] ops;
    logic                ctrl_en, ctrl_stop, ctrl_src, sync_pulse;
    logic [TRIM_W-1:0]   init_fine, eng_fine, step;
    logic                unf_evt, ovf_evt, st_unf, st_ovf;
    logic [CNT_W-1:0]    cnt;
    logic [BKT_W-1:0]    bucket;
    logic [OPQ_W-1:0]    op_sel;
    op_t                 op_type;
    logic                apply, nop_hit;

    sof_cal_regs #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W),
        .TRIM_W(TRIM_W), .COARSE_W(COARSE_W), .TARGET(TARGET)
    ) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .cfg_we     (cfg_we),
        .cfg_addr   (cfg_addr),
        .cfg_wdata  (cfg_wdata),
        .cfg_rdata  (cfg_rdata),
        .eng_fine   (eng_fine),
        .unf_evt    (unf_evt),
        .ovf_evt    (ovf_evt),
        .thr        (thr),
        .ops        (ops),
        .ctrl_en    (ctrl_en),
        .ctrl_stop  (ctrl_stop),
        .ctrl_src   (ctrl_src),
        .init_fine  (init_fine),
        .act_coarse (coarse_trim),
        .sync_pulse (sync_pulse),
        .st_unf     (st_unf),
        .st_ovf     (st_ovf),
        .irq_unf    (irq_underrun),
        .irq_ovf    (irq_overflow)
    );

    sof_cal_classify #(.CNT_W(CNT_W)) u_cls (
        .cnt    (cnt),
        .thr    (thr),
        .bucket (bucket)
    );

    assign op_sel  = ops[bucket];
    assign op_type = op_t'(op_sel[1:0]);
    assign apply   = (state == ST_MEAS) && sof_in;
    assign nop_hit = apply && !sync_pulse && (op_type == OP_NOP);

    sof_cal_trim #(.TRIM_W(TRIM_W)) u_trim (
        .clk       (clk),
        .rst_n     (rst_n),
        .hold_step (state == ST_IDLE),
        .apply     (apply),
        .op_type   (op_type),
        .op_down   (op_sel[2]),
        .sync      (sync_pulse),
        .init_fine (init_fine),
        .fine      (eng_fine),
        .step      (step),
        .unf_evt   (unf_evt),
        .ovf_evt   (ovf_evt)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nxt;
    end

    // transitions
    always_comb begin
        state_nxt = state;
        unique case (state)
            ST_IDLE: if (ctrl_en) state_nxt = ST_ARM;
            ST_ARM:  if (!ctrl_en) state_nxt = ST_IDLE;
                     else if (sof_in) state_nxt = ST_MEAS;
            ST_MEAS: if (!ctrl_en) state_nxt = ST_IDLE;
                     else if (nop_hit && ctrl_stop) state_nxt = ST_HALT;
            ST_HALT: if (!ctrl_en) state_nxt = ST_IDLE;
        endcase
    end

    // outputs: period counter and trim selection
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else begin
            unique case (state)
                ST_ARM:  if (sof_in) cnt <= CNT_ONE;
                ST_MEAS: if (sof_in) cnt <= CNT_ONE;
                         else if (cnt != CNT_MAX) cnt <= cnt + CNT_ONE;
                ST_IDLE, ST_HALT: cnt <= '0;
            endcase
        end
    end

    assign fine_trim = ctrl_src ? eng_fine : init_fine;

endmodule

// File: rtl/sof_cal_chk.sv
module sof_cal_chk
    import sof_cal_pkg::*;
#(
    parameter int TRIM_W = 5
) (
    input logic              clk,
    input logic              rst_n,
    input logic              sof_in,
    input logic              sync_pulse,
    input logic              ctrl_en,
    input cal_state_t        state,
    input logic [TRIM_W-1:0] eng_fine,
    input logic [TRIM_W-1:0] step,
    input logic              st_unf,
    input logic              st_ovf
);

    localparam logic [TRIM_W-1:0] FMAX = '1;

    a_r5_underrun_only_at_zero: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_unf) |-> ($past(eng_fine) == '0));

    a_r6_overflow_only_at_max: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_ovf) |-> ($past(eng_fine) == FMAX));

    a_r3_step_power_of_two: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(step) == 1);

    a_r2_trim_moves_only_on_sof: assert property (@(posedge clk) disable iff (!rst_n)
        (!sof_in && !sync_pulse) |=> $stable(eng_fine));

    a_r13_idle_holds_trim: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && !sync_pulse) |=> $stable(eng_fine));

    a_r10_halt_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_HALT && ctrl_en) |=> (state == ST_HALT));

endmodule

bind sof_trim_cal sof_cal_chk #(.TRIM_W(TRIM_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .sof_in     (sof_in),
    .sync_pulse (sync_pulse),
    .ctrl_en    (ctrl_en),
    .state      (state),
    .eng_fine   (eng_fine),
    .step       (step),
    .st_unf     (st_unf),
    .st_ovf     (st_ovf)
);

// File: tb/sof_trim_cal_test.sv
`timescale 1ns/1ps
module sof_trim_cal_test;

    localparam int AT = 0, AO = 8, ACTRL = 17, AIF = 18, AIC = 19, AIE = 20, AIS = 21, ASYNC = 22;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [4:0]  cfg_addr = '0;
    logic [15:0] cfg_wdata = '0;
    logic [15:0] cfg_rdata;
    logic        sof_in = 1'b0;
    logic [4:0]  fine_trim;
    logic [7:0]  coarse_trim;
    logic        irq_underrun, irq_overflow;

    sof_trim_cal uut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .sof_in(sof_in),
        .fine_trim(fine_trim), .coarse_trim(coarse_trim),
        .irq_underrun(irq_underrun), .irq_overflow(irq_overflow)
    );

    always #2.5 clk = ~clk;

    int nchk = 0, nfail = 0;
    int cyc = 0, last_sof = 0;
    bit finished = 0;
    always @(posedge clk) cyc <= cyc + 1;

    // bench model state
    int  thr[8];
    int  ops[9];
    int  m_fine = 0, m_step = 16, m_init = 16;
    bit  m_en = 0, m_arm = 0, m_halt = 0, m_stop = 0;

    // scoreboard
    int    exp_q[$];
    string tag_q[$];
    event  mon_ev;

    task automatic check(input string req, input int act, input int exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    initial forever begin
        @(mon_ev);
        while (exp_q.size() > 0) begin
            int e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            check(t, int'(fine_trim), e);
        end
    end

    task automatic wr(input int a, input int d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = 5'(a); cfg_wdata = 16'(d);
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic rd(input int a, output int v);
        cfg_addr = 5'(a);
        #1;
        v = int'(cfg_rdata);
    endtask

    function automatic int bucket_of(input int c);
        int b = 0;
        for (int i = 0; i < 8; i++) if (c >= thr[i]) b++;
        return b;
    endfunction

    task automatic model_sof(input int gap);
        int c, op;
        if (!m_en || m_halt) return;
        if (!m_arm) begin m_arm = 1; return; end
        c  = (gap > 65535) ? 65535 : gap;
        op = ops[bucket_of(c)];
        case (op & 3)
            0: if (m_stop) m_halt = 1;
            1: begin
                if (op & 16) m_fine = (m_fine < m_step) ? 0 : m_fine - m_step;
                else         m_fine = (m_fine + m_step > 31) ? 31 : m_fine + m_step;
                m_step = (m_step > 1) ? m_step / 2 : 1;
            end
            2: m_fine = (m_fine == 31) ? 31 : m_fine + 1;
            default: m_fine = (m_fine == 0) ? 0 : m_fine - 1;
        endcase
    endtask

    // driver: SOF sampled 'gap' edges after the previous one
    task automatic sof_gap(input int gap, input string tag);
        int prev;
        while (cyc < last_sof + gap - 1) @(negedge clk);
        sof_in = 1'b1;
        @(negedge clk);
        sof_in = 1'b0;
        prev = last_sof;
        last_sof = cyc;
        model_sof(last_sof - prev);
        exp_q.push_back(m_fine);
        tag_q.push_back(tag);
        ->mon_ev;
        #0;
    endtask

    task automatic set_ctrl(input bit en, input bit stop, input bit src);
        if (en && !m_en) begin m_arm = 0; m_halt = 0; m_step = 16; end
        if (!en) m_step = 16;
        m_en = en; m_stop = stop;
        wr(ACTRL, (int'(en)) | (int'(stop) << 2) | (int'(src) << 3));
    endtask

    task automatic do_sync();
        wr(ASYNC, 0);
        m_fine = m_init; m_step = 16;
    endtask

    initial begin
        int v;
        for (int i = 0; i < 8; i++) thr[i] = 100 + 10 * i;
        ops = '{0, 'h11, 'h11, 3, 0, 0, 2, 1, 1};
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        rd(AT + 0, v); check("R1 thr0", v, 16800);
        rd(AT + 3, v); check("R1 thr3", v, 23970);
        rd(AT + 5, v); check("R1 thr5", v, 24030);
        rd(AT + 7, v); check("R1 thr7", v, 28800);
        rd(AO + 1, v); check("R1 op1", v, 'h11);
        rd(AO + 3, v); check("R1 op3", v, 3);
        rd(AO + 6, v); check("R1 op6", v, 2);
        rd(AO + 8, v); check("R1 op8", v, 1);
        check("R1 fine", int'(fine_trim), 16);
        check("R1 irq", int'({irq_underrun, irq_overflow}), 0);

        for (int i = 0; i < 8; i++) wr(AT + i, thr[i]);

        // R11 source select: initial register shown
        wr(AIF, 7);
        check("R11 src0", int'(fine_trim), 7);
        m_init = 16; wr(AIF, 16);

        // R13 disabled engine ignores SOF
        set_ctrl(0, 0, 1);
        do_sync();
        check("R12 sync fine", int'(fine_trim), 16);
        sof_gap(40, "R13 off");
        sof_gap(105, "R13 off");
        sof_gap(105, "R13 off");

        // R8 first SOF only arms; R2/R3/R4 bucket walk
        set_ctrl(1, 0, 1);
        sof_gap(200, "R8 first");
        sof_gap(105, "R3 bin down");
        sof_gap(175, "R3 bin up");
        sof_gap(165, "R3 bin up b7");
        sof_gap(115, "R3 bin down b2");
        sof_gap(125, "R4 sub");
        sof_gap(145, "R4 nop deadband");
        sof_gap(155, "R4 add");
        sof_gap(50, "R2 glitch");
        sof_gap(105, "R3 step floor");
        sof_gap(135, "R4 nop b4");

        // R5 underrun
        m_init = 1; wr(AIF, 1); do_sync();
        sof_gap(125, "R5 sub to 0");
        sof_gap(125, "R5 at 0");
        @(negedge clk);
        rd(AIS, v); check("R5 status", v, 4);
        check("R7 irq gated", int'(irq_underrun), 0);
        wr(AIE, 4);
        check("R7 irq unf", int'(irq_underrun), 1);
        wr(AIS, 4);
        check("R7 w1c", int'(irq_underrun), 0);
        m_init = 3; wr(AIF, 3); do_sync();
        sof_gap(105, "R5 clamp");
        rd(AIS, v); check("R5 clamp no flag", v, 0);

        // R6 overflow
        m_init = 30; wr(AIF, 30); do_sync();
        sof_gap(155, "R6 add to 31");
        sof_gap(155, "R6 at 31");
        rd(AIS, v); check("R6 status", v, 8);
        wr(AIE, 12);
        check("R7 irq ovf", int'(irq_overflow), 1);
        wr(AIS, 8);
        check("R7 w1c ovf", int'(irq_overflow), 0);

        // R12 coarse pass-through via sync
        wr(AIC, 'h5A);
        check("R12 coarse before sync", int'(coarse_trim), 0);
        do_sync();
        check("R12 coarse", int'(coarse_trim), 'h5A);

        // R10 stop on no-op
        set_ctrl(1, 1, 1);
        sof_gap(145, "R10 nop halts");
        sof_gap(155, "R10 halted");
        sof_gap(105, "R10 halted");
        m_init = 5; wr(AIF, 5); do_sync();
        set_ctrl(0, 1, 1);
        set_ctrl(1, 1, 1);
        sof_gap(60, "R10 rearm");
        sof_gap(175, "R10 restart step");
        set_ctrl(1, 0, 1);
        sof_gap(145, "R10 keeps running");
        sof_gap(155, "R10 keeps running");

        // R9 saturation reaches top bucket only if count saturates
        thr[7] = 65535; wr(AT + 7, 65535);
        ops[7] = 0;     wr(AO + 7, 0);
        m_init = 5; wr(AIF, 5); do_sync();
        sof_gap(66000, "R9 saturate");

        repeat (2) @(negedge clk);
        if (!finished) begin
            finished = 1;
            $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
            $finish;
        end
    end

    initial begin
        #(5 * 150000);
        if (!finished) begin
            finished = 1;
            nchk++; nfail++;
            $display("FAIL watchdog actual=timeout expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
            $finish;
        end
    end

endmodule